// File: doc/BRIEF.md
# Byte-Level Bus Master Sequencer

This block is the master sequencer of a two-wire serial bus controller, working at byte granularity. Software programs a control word, a target address and a byte count. The sequencer then issues abstract operations to a bus port: a start with address and direction, a byte send that returns an acknowledge, a byte receive, and a stop. Each operation uses a valid/ready handshake. Bytes to send are taken from an external packing buffer, and received bytes are pushed into it. The sequencer raises sticky flags for address-access ready, negative acknowledge, receive ready and transmit ready. Clock-level waveform timing, slave operation and 10-bit addressing are handled elsewhere or not at all.

There are two modes. In count mode, a working counter limits the transfer. When the counter reaches zero, the sequencer either issues a stop and reloads the counter, or it pauses the bus, flags access-ready and drops the master bit so that software can issue a repeated start. In repeat mode, the counter is ignored. The sequencer keeps the buffer drained or filled until software sets the stop bit.

Top module: `bms_seq`

## Requirements
- R1: The control word holds only the bits in mask 0xCF07 (enable 15, master 10, direction 9, repeat 2, stop 1, start 0). After reset the control word, the target, both counts and the flags are zero.
- R2: A control write with bit 15 clear is a soft reset. It clears the control word, the target, the programmed count, the working count and all flags, and it returns the sequencer to idle. Any pending operation is dropped.
- R3: While idle with bits 15, 10 and 0 set, the sequencer issues a start operation (op kind 0). The start carries the target and has op_rd_o equal to the inverse of bit 9. Bit 0 clears itself, and the working count is loaded from the programmed count.
- R4: A start that is not acknowledged sets the NACK flag (flags bit 0) and clears bit 1. No byte operation follows, and busy_o returns low.
- R5: In count mode with bit 9 set, the sequencer sends buffer bytes in order (op kind 1) and decrements the working count once per byte. While the count is non-zero and the buffer is empty, it sets the transmit-ready flag (flags bit 3).
- R6: In count mode with bit 9 clear, the sequencer receives bytes (op kind 2) while the count is non-zero and the buffer holds fewer than 4 bytes. Each received byte is pushed and sets the receive-ready flag (flags bit 2).
- R7: When the working count is zero and bit 1 is set, the sequencer issues a stop (op kind 3), clears bit 1, reloads the working count from the programmed count and goes idle.
- R8: When the working count is zero and bit 1 is clear, the sequencer sets access-ready (flags bit 1), clears bit 10 and holds the bus busy with no operation. From there a new start request issues a repeated start, or bit 1 issues a stop.
- R9: In repeat mode (bit 2), the count is neither checked nor decremented. Transmit drains the buffer and receive fills it to 4 bytes. Setting bit 1 issues a stop and reloads the working count.
- R10: A send that is not acknowledged sets NACK, clears bit 1 and halts byte operations while the bus stays busy.
- R11: cnt_o shows the working remaining count, not the programmed value.
- R12: An operation stays valid with a stable kind until it is accepted. A byte is never taken from an empty buffer or pushed into a full one.
- R13: Flags are sticky. A bit set in flag_clr_i clears the matching flag unless the same flag is being set in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word write data |
| tar_we_i | input | 1 | Target address write strobe |
| tar_wdata_i | input | TAR_W | Target address write data |
| cnt_we_i | input | 1 | Programmed count write strobe |
| cnt_wdata_i | input | CNT_W | Programmed count write data |
| flag_clr_i | input | 4 | Write-one-to-clear for the flags |
| ctrl_o | output | 16 | Current control word |
| tar_o | output | TAR_W | Current target address |
| cnt_o | output | CNT_W | Working remaining count |
| flags_o | output | 4 | {xrdy, rrdy, ardy, nack} |
| busy_o | output | 1 | Bus held by the sequencer |
| op_valid_o | output | 1 | Bus operation request |
| op_kind_o | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| op_tar_o | output | TAR_W | Address for a start |
| op_rd_o | output | 1 | Read direction for a start |
| op_wdata_o | output | 8 | Byte for a send |
| op_ready_i | input | 1 | Bus port accepts the operation |
| op_ack_i | input | 1 | Acknowledge result of a start or send |
| op_rdata_i | input | 8 | Byte returned by a receive |
| txb_avail_i | input | 1 | Transmit buffer holds a byte |
| txb_data_i | input | 8 | Oldest transmit byte |
| txb_pop_o | output | 1 | Remove the oldest transmit byte |
| rxb_level_i | input | LVL_W | Bytes held in the receive buffer |
| rxb_push_o | output | 1 | Push a received byte |
| rxb_data_o | output | 8 | Received byte |

## Verification
The hardest cases are the paused states. One is the hold after a count runs out without a stop, which must then accept a repeated start. The other is the hold after a mid-transfer send NACK, which only a stop can release. The stimulus reaches both through a bus model that refuses a chosen send index or the address, followed by later control writes. A vector table sweeps count, buffer fill and stop combinations in both directions, including a receive that stalls on a full buffer. Repeat mode is driven past a count of zero and resumed by draining the receive buffer. A stalling bus port exercises the handshake while the order of the sent bytes is checked.

// File: rtl/bms_pkg.sv
package bms_pkg;
  localparam logic [15:0] CTRL_KEEP = 16'hCF07;
  localparam int B_EN  = 15;
  localparam int B_MST = 10;
  localparam int B_TRX = 9;
  localparam int B_RPT = 2;
  localparam int B_STP = 1;
  localparam int B_STT = 0;

  localparam int F_NACK  = 0;
  localparam int F_ARDY  = 1;
  localparam int F_RRDY  = 2;
  localparam int F_XRDY  = 3;
  localparam int N_FLAGS = 4;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_RUN, S_SEND, S_RECV, S_STOP, S_HOLD
  } seq_state_e;

  typedef struct packed {
    logic clr_stt;
    logic clr_stp;
    logic clr_mst;
    logic cnt_dec;
    logic cnt_load;
  } reg_upd_t;
endpackage

// File: rtl/bms_regs.sv
module bms_regs
  import bms_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TAR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             ctrl_we_i,
  input  logic [15:0]      ctrl_wdata_i,
  input  logic             tar_we_i,
  input  logic [TAR_W-1:0] tar_wdata_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  reg_upd_t         upd_i,
  output logic [15:0]      ctrl_o,
  output logic [TAR_W-1:0] tar_o,
  output logic [CNT_W-1:0] prog_o,
  output logic [CNT_W-1:0] work_o
);
  logic [15:0] clr_mask;

  always_comb begin
    clr_mask = '1;
    if (upd_i.clr_stt) clr_mask[B_STT] = 1'b0;
    if (upd_i.clr_stp) clr_mask[B_STP] = 1'b0;
    if (upd_i.clr_mst) clr_mask[B_MST] = 1'b0;
  end

  // host write wins over sequencer bit clears in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_o <= '0;
    else if (soft_rst_i) ctrl_o <= '0;
    else if (ctrl_we_i)  ctrl_o <= ctrl_wdata_i & CTRL_KEEP;
    else                 ctrl_o <= ctrl_o & clr_mask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tar_o  <= '0;
      prog_o <= '0;
    end else if (soft_rst_i) begin
      tar_o  <= '0;
      prog_o <= '0;
    end else begin
      if (tar_we_i) tar_o  <= tar_wdata_i;
      if (cnt_we_i) prog_o <= cnt_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             work_o <= '0;
    else if (soft_rst_i)     work_o <= '0;
    else if (upd_i.cnt_load) work_o <= prog_o;
    else if (upd_i.cnt_dec)  work_o <= work_o - 1'b1;
  end
endmodule

// File: rtl/bms_flags.sv
module bms_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         flags_o[i] <= 1'b0;
      else if (soft_rst_i) flags_o[i] <= 1'b0;
      else if (set_i[i])   flags_o[i] <= 1'b1;
      else if (clr_i[i])   flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/bms_fsm.sv
module bms_fsm
  import bms_pkg::*;
#(
  parameter int BUF_DEPTH = 4,
  parameter int LVL_W     = $clog2(BUF_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               en_i,
  input  logic               mst_i,
  input  logic               trx_i,
  input  logic               rpt_i,
  input  logic               stp_i,
  input  logic               stt_i,
  input  logic               cnt_zero_i,
  input  logic               txb_avail_i,
  input  logic [LVL_W-1:0]   rxb_level_i,
  input  logic               op_ready_i,
  input  logic               op_ack_i,
  output logic               op_valid_o,
  output op_kind_e           op_kind_o,
  output logic               txb_pop_o,
  output logic               rxb_push_o,
  output reg_upd_t           upd_o,
  output logic [N_FLAGS-1:0] flag_set_o,
  output logic               busy_o
);
  seq_state_e state, nxt;
  logic rx_full;
  logic start_req;

  assign rx_full   = rxb_level_i >= LVL_W'(BUF_DEPTH);
  assign start_req = en_i && mst_i && stt_i;

  always_comb begin
    nxt        = state;
    upd_o      = '0;
    flag_set_o = '0;
    txb_pop_o  = 1'b0;
    rxb_push_o = 1'b0;
    unique case (state)
      S_IDLE: if (start_req) begin
        nxt = S_START;
        upd_o.clr_stt  = 1'b1;
        upd_o.cnt_load = 1'b1;
      end
      S_START: if (op_ready_i) begin
        if (op_ack_i) nxt = S_RUN;
        else begin
          flag_set_o[F_NACK] = 1'b1;
          upd_o.clr_stp = 1'b1;
          nxt = S_IDLE;
        end
      end
      S_RUN: begin
        if (rpt_i) begin
          if (stp_i) nxt = S_STOP;
          else if (trx_i) begin
            if (txb_avail_i) nxt = S_SEND;
            else flag_set_o[F_XRDY] = 1'b1;
          end else if (!rx_full) nxt = S_RECV;
          else flag_set_o[F_RRDY] = 1'b1;
        end else if (cnt_zero_i) begin
          if (stp_i) nxt = S_STOP;
          else begin
            flag_set_o[F_ARDY] = 1'b1;
            upd_o.clr_mst = 1'b1;
            nxt = S_HOLD;
          end
        end else if (trx_i) begin
          if (txb_avail_i) nxt = S_SEND;
          else flag_set_o[F_XRDY] = 1'b1;
        end else if (!rx_full) nxt = S_RECV;
      end
      S_SEND: if (op_ready_i) begin
        txb_pop_o     = 1'b1;
        upd_o.cnt_dec = !rpt_i;
        if (!op_ack_i) begin
          flag_set_o[F_NACK] = 1'b1;
          upd_o.clr_stp = 1'b1;
          nxt = S_HOLD;
        end else nxt = S_RUN;
      end
      S_RECV: if (op_ready_i) begin
        rxb_push_o          = 1'b1;
        flag_set_o[F_RRDY]  = 1'b1;
        upd_o.cnt_dec       = !rpt_i;
        nxt = S_RUN;
      end
      S_STOP: if (op_ready_i) begin
        upd_o.clr_stp  = 1'b1;
        upd_o.cnt_load = 1'b1;
        nxt = S_IDLE;
      end
      S_HOLD: begin
        if (start_req) begin
          nxt = S_START;
          upd_o.clr_stt  = 1'b1;
          upd_o.cnt_load = 1'b1;
        end else if (stp_i) nxt = S_STOP;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         state <= S_IDLE;
    else if (soft_rst_i) state <= S_IDLE;
    else                 state <= nxt;
  end

  always_comb begin
    op_valid_o = 1'b1;
    op_kind_o  = OP_START;
    unique case (state)
      S_START: op_kind_o = OP_START;
      S_SEND:  op_kind_o = OP_SEND;
      S_RECV:  op_kind_o = OP_RECV;
      S_STOP:  op_kind_o = OP_STOP;
      default: op_valid_o = 1'b0;
    endcase
  end

  assign busy_o = state != S_IDLE;

  a_r12_op_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !op_ready_i && !soft_rst_i) |=> (op_valid_o && $stable(op_kind_o)));
  a_r12_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txb_pop_o |-> txb_avail_i);
  a_r12_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxb_push_o |-> (rxb_level_i < LVL_W'(BUF_DEPTH)));
  a_r5_count_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_kind_o == OP_SEND && !rpt_i) |-> !cnt_zero_i);
endmodule

// File: rtl/bms_seq.sv
module bms_seq
  import bms_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int TAR_W     = 10,
  parameter int BUF_DEPTH = 4,
  localparam int LVL_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic [15:0]        ctrl_wdata_i,
  input  logic               tar_we_i,
  input  logic [TAR_W-1:0]   tar_wdata_i,
  input  logic               cnt_we_i,
  input  logic [CNT_W-1:0]   cnt_wdata_i,
  input  logic [N_FLAGS-1:0] flag_clr_i,
  output logic [15:0]        ctrl_o,
  output logic [TAR_W-1:0]   tar_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [N_FLAGS-1:0] flags_o,
  output logic               busy_o,
  output logic               op_valid_o,
  output logic [1:0]         op_kind_o,
  output logic [TAR_W-1:0]   op_tar_o,
  output logic               op_rd_o,
  output logic [7:0]         op_wdata_o,
  input  logic               op_ready_i,
  input  logic               op_ack_i,
  input  logic [7:0]         op_rdata_i,
  input  logic               txb_avail_i,
  input  logic [7:0]         txb_data_i,
  output logic               txb_pop_o,
  input  logic [LVL_W-1:0]   rxb_level_i,
  output logic               rxb_push_o,
  output logic [7:0]         rxb_data_o
);
  logic               soft_rst;
  reg_upd_t           upd;
  logic [CNT_W-1:0]   prog;
  logic [N_FLAGS-1:0] fset;
  op_kind_e           kind;

  assign soft_rst = ctrl_we_i && !ctrl_wdata_i[B_EN];

  bms_regs #(.CNT_W(CNT_W), .TAR_W(TAR_W)) u_regs (
    .clk_i, .rst_ni,
    .soft_rst_i   (soft_rst),
    .ctrl_we_i, .ctrl_wdata_i,
    .tar_we_i, .tar_wdata_i,
    .cnt_we_i, .cnt_wdata_i,
    .upd_i        (upd),
    .ctrl_o,
    .tar_o,
    .prog_o       (prog),
    .work_o       (cnt_o)
  );

  bms_fsm #(.BUF_DEPTH(BUF_DEPTH), .LVL_W(LVL_W)) u_fsm (
    .clk_i, .rst_ni,
    .soft_rst_i   (soft_rst),
    .en_i         (ctrl_o[B_EN]),
    .mst_i        (ctrl_o[B_MST]),
    .trx_i        (ctrl_o[B_TRX]),
    .rpt_i        (ctrl_o[B_RPT]),
    .stp_i        (ctrl_o[B_STP]),
    .stt_i        (ctrl_o[B_STT]),
    .cnt_zero_i   (cnt_o == '0),
    .txb_avail_i,
    .rxb_level_i,
    .op_ready_i,
    .op_ack_i,
    .op_valid_o,
    .op_kind_o    (kind),
    .txb_pop_o,
    .rxb_push_o,
    .upd_o        (upd),
    .flag_set_o   (fset),
    .busy_o
  );

  bms_flags #(.N(N_FLAGS)) u_flags (
    .clk_i, .rst_ni,
    .soft_rst_i   (soft_rst),
    .set_i        (fset),
    .clr_i        (flag_clr_i),
    .flags_o
  );

  assign op_kind_o  = kind;
  assign op_tar_o   = tar_o;
  assign op_rd_o    = !ctrl_o[B_TRX];
  assign op_wdata_o = txb_data_i;
  assign rxb_data_o = op_rdata_i;

  a_r10_send_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_kind_o == OP_SEND && op_ready_i && !op_ack_i && !ctrl_we_i)
    |=> (flags_o[F_NACK] && !ctrl_o[B_STP] && busy_o));
  a_r7_stop_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_kind_o == OP_STOP && op_ready_i && !ctrl_we_i && !cnt_we_i)
    |=> (cnt_o == prog && !busy_o));
endmodule

// File: tb/bms_seq_test.sv
`timescale 1ns/1ps
module bms_seq_test;
  localparam int CNT_W = 16;
  localparam int TAR_W = 10;
  localparam int LVL_W = 3;

  localparam logic [15:0] EN = 16'h8000, MST = 16'h0400, TRX = 16'h0200,
                          RPT = 16'h0004, STP = 16'h0002, STT = 16'h0001;

  logic clk_i = 0, rst_ni = 0;
  always #10 clk_i = ~clk_i;

  logic             ctrl_we_i = 0, tar_we_i = 0, cnt_we_i = 0;
  logic [15:0]      ctrl_wdata_i = 0;
  logic [TAR_W-1:0] tar_wdata_i = 0;
  logic [CNT_W-1:0] cnt_wdata_i = 0;
  logic [3:0]       flag_clr_i = 0;
  logic [15:0]      ctrl_o;
  logic [TAR_W-1:0] tar_o, op_tar_o;
  logic [CNT_W-1:0] cnt_o;
  logic [3:0]       flags_o;
  logic             busy_o, op_valid_o, op_rd_o, op_ready_i, op_ack_i;
  logic [1:0]       op_kind_o;
  logic [7:0]       op_wdata_o, op_rdata_i, txb_data_i, rxb_data_o;
  logic             txb_avail_i, txb_pop_o, rxb_push_o;
  logic [LVL_W-1:0] rxb_level_i;

  bms_seq uut (.*);

  // bus port and buffer models
  logic       m_clr = 0, tx_load = 0, rx_drain = 0, stall_en = 0, nack_start = 0;
  logic [7:0] tx_byte = 0;
  int         nack_at = -1;
  logic [7:0] tx_mem [16];
  logic [7:0] sent_mem [16];
  logic [7:0] rx_mem [16];
  int tx_rd = 0, tx_wr = 0, rx_n = 0, rx_wr = 0;
  int nstart = 0, nsend = 0, nrecv = 0, nstop = 0, cyc = 0;
  logic [TAR_W-1:0] st_tar = 0;
  logic st_rd = 0;

  assign txb_avail_i = (tx_wr - tx_rd) > 0;
  assign txb_data_i  = tx_mem[tx_rd[3:0]];
  assign rxb_level_i = LVL_W'(rx_n);
  assign op_ready_i  = op_valid_o && (!stall_en || (cyc % 3 == 0));
  assign op_ack_i    = !((op_kind_o == 2'd0) && nack_start) && !((op_kind_o == 2'd1) && (nsend == nack_at));
  assign op_rdata_i  = 8'hA0 + 8'(nrecv);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (m_clr) begin
      tx_rd <= 0; tx_wr <= 0; rx_n <= 0; rx_wr <= 0;
      nstart <= 0; nsend <= 0; nrecv <= 0; nstop <= 0;
    end else begin
      if (tx_load) begin tx_mem[tx_wr[3:0]] <= tx_byte; tx_wr <= tx_wr + 1; end
      if (txb_pop_o) tx_rd <= tx_rd + 1;
      if (rxb_push_o) begin rx_mem[rx_wr[3:0]] <= rxb_data_o; rx_wr <= rx_wr + 1; end
      rx_n <= rx_n + (rxb_push_o ? 1 : 0) - (rx_drain ? 1 : 0);
      if (op_valid_o && op_ready_i) begin
        case (op_kind_o)
          2'd0: begin nstart <= nstart + 1; st_tar <= op_tar_o; st_rd <= op_rd_o; end
          2'd1: begin sent_mem[nsend[3:0]] <= op_wdata_o; nsend <= nsend + 1; end
          2'd2: nrecv <= nrecv + 1;
          default: nstop <= nstop + 1;
        endcase
      end
    end
  end

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    @(negedge clk_i); ctrl_we_i = 1; ctrl_wdata_i = v;
    @(negedge clk_i); ctrl_we_i = 0;
  endtask
  task automatic wr_tar(input logic [TAR_W-1:0] v);
    @(negedge clk_i); tar_we_i = 1; tar_wdata_i = v;
    @(negedge clk_i); tar_we_i = 0;
  endtask
  task automatic wr_cnt(input int v);
    @(negedge clk_i); cnt_we_i = 1; cnt_wdata_i = CNT_W'(v);
    @(negedge clk_i); cnt_we_i = 0;
  endtask
  task automatic load_tx(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tx_load = 1; tx_byte = 8'h10 + 8'(i);
    end
    @(negedge clk_i); tx_load = 0;
  endtask
  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk_i); rx_drain = 1; end
    @(negedge clk_i); rx_drain = 0;
  endtask
  task automatic fresh();
    wr_ctrl(16'h0000);
    @(negedge clk_i); m_clr = 1;
    @(negedge clk_i); m_clr = 0;
    nack_at = -1; nack_start = 0; stall_en = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  typedef struct packed {
    logic       rx;
    logic [2:0] nb;
    logic [3:0] cnt;
    logic       stp;
    logic [2:0] ops;
    logic [3:0] ecnt;
    logic       busy;
    logic       ardy;
    logic       xrdy;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 3'd3, 4'd3, 1'b1, 3'd3, 4'd3, 1'b0, 1'b0, 1'b0},
    '{1'b0, 3'd2, 4'd2, 1'b0, 3'd2, 4'd0, 1'b1, 1'b1, 1'b0},
    '{1'b0, 3'd4, 4'd2, 1'b1, 3'd2, 4'd2, 1'b0, 1'b0, 1'b0},
    '{1'b0, 3'd1, 4'd3, 1'b1, 3'd1, 4'd2, 1'b1, 1'b0, 1'b1},
    '{1'b1, 3'd0, 4'd3, 1'b1, 3'd3, 4'd3, 1'b0, 1'b0, 1'b0},
    '{1'b1, 3'd0, 4'd6, 1'b1, 3'd4, 4'd2, 1'b1, 1'b0, 1'b0},
    '{1'b1, 3'd0, 4'd2, 1'b0, 3'd2, 4'd0, 1'b1, 1'b1, 1'b0}
  };

  initial begin
    idle(3);
    @(negedge clk_i); rst_ni = 1;
    idle(1);
    // R1 / R11 reset state
    chk("R1 reset ctrl", ctrl_o, 0);
    chk("R11 reset cnt", cnt_o, 0);
    chk("R1 reset flags", flags_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R12 reset op_valid", op_valid_o, 0);

    // R1 mask
    wr_ctrl(16'hB0F8);
    chk("R1 mask a", ctrl_o, 16'h8000);
    wr_ctrl(16'hCEF6);
    idle(4);
    chk("R1 mask b", ctrl_o, 16'hCE06);
    chk("R1 no start without bit0", busy_o, 0);

    // vector table: count mode, R5 R6 R7 R8 R11
    foreach (VECS[k]) begin
      fresh();
      wr_tar(10'h055);
      wr_cnt(int'(VECS[k].cnt));
      if (!VECS[k].rx) load_tx(int'(VECS[k].nb));
      wr_ctrl(EN | MST | STT | (VECS[k].rx ? 16'h0 : TRX) | (VECS[k].stp ? STP : 16'h0));
      idle(40);
      chk($sformatf("R5_R6 v%0d byte ops", k), VECS[k].rx ? nrecv : nsend, int'(VECS[k].ops));
      chk($sformatf("R11 v%0d cnt", k), cnt_o, int'(VECS[k].ecnt));
      chk($sformatf("R7 v%0d busy", k), busy_o, int'(VECS[k].busy));
      chk($sformatf("R7 v%0d stops", k), nstop, (VECS[k].stp && !VECS[k].busy) ? 1 : 0);
      chk($sformatf("R8 v%0d ardy", k), flags_o[1], int'(VECS[k].ardy));
      chk($sformatf("R8 v%0d mst", k), ctrl_o[10], int'(!VECS[k].ardy));
      chk($sformatf("R7 v%0d stp", k), ctrl_o[1], int'(VECS[k].stp && VECS[k].busy));
      chk($sformatf("R5 v%0d xrdy", k), flags_o[3], int'(VECS[k].xrdy));
      chk($sformatf("R6 v%0d rrdy", k), flags_o[2], int'(VECS[k].rx));
    end

    // R3 start fields, read direction
    fresh();
    wr_tar(10'h3A5);
    wr_cnt(1);
    wr_ctrl(EN | MST | STP | STT);
    idle(20);
    chk("R3 start tar", st_tar, 10'h3A5);
    chk("R3 start rd", st_rd, 1);
    chk("R3 start self-clear", ctrl_o[0], 0);
    chk("R6 rx data", rx_mem[0], 8'hA0);
    // R3 write direction
    fresh();
    wr_cnt(1); load_tx(1);
    wr_ctrl(EN | MST | TRX | STP | STT);
    idle(20);
    chk("R3 start rd tx", st_rd, 0);
    chk("R3 nstart", nstart, 1);

    // R4 address nack, then R13 flag clear
    fresh();
    nack_start = 1;
    wr_cnt(3); load_tx(3);
    wr_ctrl(EN | MST | TRX | STP | STT);
    idle(20);
    chk("R4 nack flag", flags_o[0], 1);
    chk("R4 stp cleared", ctrl_o[1], 0);
    chk("R4 busy", busy_o, 0);
    chk("R4 no sends", nsend, 0);
    @(negedge clk_i); flag_clr_i = 4'b0001;
    @(negedge clk_i); flag_clr_i = 4'b0000;
    chk("R13 flag cleared", flags_o, 0);

    // R10 send nack mid transfer
    fresh();
    nack_at = 1;
    wr_cnt(3); load_tx(3);
    wr_ctrl(EN | MST | TRX | STP | STT);
    idle(30);
    chk("R10 sends", nsend, 2);
    chk("R10 nack flag", flags_o[0], 1);
    chk("R10 stp cleared", ctrl_o[1], 0);
    chk("R10 busy held", busy_o, 1);
    chk("R10 cnt", cnt_o, 1);
    wr_ctrl(EN | MST | TRX | STP);
    idle(10);
    chk("R10 stop after hold", nstop, 1);
    chk("R10 released", busy_o, 0);

    // R8 repeated start from pause
    fresh();
    wr_cnt(2); load_tx(2);
    wr_ctrl(EN | MST | TRX | STT);
    idle(30);
    chk("R8 paused", busy_o, 1);
    load_tx(2);
    wr_ctrl(EN | MST | TRX | STP | STT);
    idle(30);
    chk("R8 restarts", nstart, 2);
    chk("R8 total sends", nsend, 4);
    chk("R8 ended", busy_o, 0);
    chk("R7 reload after restart", cnt_o, 2);

    // R9 repeat transmit ignores count
    fresh();
    wr_cnt(1); load_tx(3);
    wr_ctrl(EN | MST | TRX | RPT | STT);
    idle(30);
    chk("R9 sends past count", nsend, 3);
    chk("R9 count untouched", cnt_o, 1);
    chk("R9 busy", busy_o, 1);
    chk("R9 xrdy", flags_o[3], 1);
    wr_cnt(5);
    wr_ctrl(EN | MST | TRX | RPT | STP);
    idle(10);
    chk("R9 stop", nstop, 1);
    chk("R9 reload", cnt_o, 5);
    chk("R9 stp cleared", ctrl_o[1], 0);
    chk("R9 idle", busy_o, 0);

    // R9 repeat receive fills buffer, R12 no push when full
    fresh();
    wr_ctrl(EN | MST | RPT | STT);
    idle(30);
    chk("R9 rx fills", nrecv, 4);
    chk("R12 rx level", rxb_level_i, 4);
    drain(2);
    idle(20);
    chk("R9 rx resumes", nrecv, 6);

    // R2 soft reset mid transfer
    wr_tar(10'h123);
    wr_cnt(9);
    wr_ctrl(MST);
    idle(2);
    chk("R2 ctrl", ctrl_o, 0);
    chk("R2 tar", tar_o, 0);
    chk("R2 cnt", cnt_o, 0);
    chk("R2 flags", flags_o, 0);
    chk("R2 busy", busy_o, 0);
    chk("R2 op_valid", op_valid_o, 0);

    // R12 stalling bus keeps order
    fresh();
    stall_en = 1;
    wr_cnt(3); load_tx(3);
    wr_ctrl(EN | MST | TRX | STP | STT);
    idle(80);
    chk("R12 stall sends", nsend, 3);
    chk("R12 byte0", sent_mem[0], 8'h10);
    chk("R12 byte1", sent_mem[1], 8'h11);
    chk("R12 byte2", sent_mem[2], 8'h12);
    chk("R12 stall done", busy_o, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule